// File: doc/BRIEF.md
# Masked Error Capture and Bit Error Counter

This block sits behind a sampling analyzer channel. Each cycle it may receive one sampled word together with the word it should have been, and a per-bit mask. The expected word can come from pattern memory or from a pseudo-random reference. A segment-valid flag marks cycles that belong to the running pattern. A segment-mask flag removes a whole word from comparison. When the design runs, the mode input picks one of three measurements:

- **Capture only.** The block records the raw samples and makes no comparison.
- **Error capture.** The block compares every word and keeps a short window of samples around the first mismatch. The window lies either before the mismatch or after it. The buffer is split in two halves: one half holds the received words and the other holds the expected words at matching positions.
- **Counting.** The block stores nothing. It keeps saturating totals of the compared bits and of the mismatched bits. These totals can be read at any time while the measurement runs.

A registered error flag goes out to the sequencer's event logic whenever a compared word has an unmasked mismatch. Software turns the two totals into an error ratio.

Top module: `err_cap_ber`

## Requirements
- R1: After reset both totals are zero, and the overflow flag, error flag, fill count and done flag are all low or zero.
- R2: Mode codes are 2'b00 for capture only, 2'b01 for error capture, and 2'b10 or 2'b11 for counting. In capture only, the totals never change and the error flag stays low.
- R3: A start pulse begins a measurement and a stop pulse ends it; when both are high in the same cycle, start wins. A word is accepted only while a measurement runs and both the input-valid and segment-valid flags are high.
- R4: For each accepted word in any comparing mode (every mode except 2'b00), the bit total rises by the number of zero bits in the per-bit mask, and the error total rises by the popcount of (sample XOR expected) AND NOT mask.
- R5: An accepted word that carries the segment-mask flag changes neither total and raises no error flag.
- R6: The error flag is high in the cycle after an accepted, compared word that has at least one unmasked mismatching bit. In every other cycle it is low.
- R7: In capture only, accepted words fill the buffer in order from address 0 up to DEPTH. The done flag then rises and later words are dropped. Read address k returns the k-th stored word.
- R8: In error capture, logical read addresses 0 to DEPTH/2-1 return the stored samples, oldest first. Address DEPTH/2+k returns the expected word that was compared with sample k.
- R9: With the before-error option set (pre_trig = 1), the sample half acts as a circular window. It freezes on the first error, and the erroring word is kept as the newest entry. The fill count stays at most DEPTH/2.
- R10: With the before-error option clear (pre_trig = 0), nothing is stored until the first error. Storing starts with the erroring word and stops once DEPTH/2 words are held. Words whose mismatch lies only in masked bits never start storage.
- R11: Both totals saturate at all-ones instead of wrapping. The overflow flag rises on the first saturation and stays set until a clear.
- R12: Clear zeroes both totals and the overflow flag, and re-arms capture (fill count zero, done low). Clear has no effect while a measurement runs in mode 2'b00 or 2'b01. In the counting modes it acts at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Measurement mode select |
| pre_trig | input | 1 | 1: keep window before first error; 0: after it |
| start | input | 1 | Begin measurement (pulse) |
| stop | input | 1 | End measurement (pulse) |
| clear | input | 1 | Clear totals and re-arm capture |
| in_valid | input | 1 | Sampled word present this cycle |
| smp_data | input | W | Sampled word |
| exp_data | input | W | Expected word |
| bit_mask | input | W | 1 = bit excluded from comparison |
| seg_valid | input | 1 | Word belongs to the active segment |
| seg_mask | input | 1 | Whole word excluded from comparison |
| rd_addr | input | log2(DEPTH) | Capture buffer read address |
| rd_data | output | W | Capture buffer read data |
| err_evt | output | 1 | Unmasked mismatch seen last cycle |
| bit_cnt | output | CW | Compared-bit total |
| err_cnt | output | CW | Mismatched-bit total |
| cnt_ovf | output | 1 | Sticky saturation flag |
| cap_fill | output | log2(DEPTH)+1 | Words currently held in the buffer |
| cap_done | output | 1 | Capture window complete |

## Verification
The bound checker watches several invariants on every cycle:

- The error total never exceeds the bit total.
- The totals never decrease except on clear, and stay frozen in capture-only mode.
- The overflow and done flags are sticky.
- The fill count stays within the buffer, or within its half in error capture.
- The error flag only ever follows a comparing mode.

Exact increments need the bench's scenarios. The same holds for the order and content of the before- and after-error windows, the exact saturation point, and whether clear is honored or ignored. The bench sweeps every sample, expected and mask combination of a four-bit lane, and computes the totals arithmetically.

// File: rtl/err_cap_ber.sv
module err_cap_ber #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          pre_trig,
  input  logic          start,
  input  logic          stop,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [W-1:0]  smp_data,
  input  logic [W-1:0]  exp_data,
  input  logic [W-1:0]  bit_mask,
  input  logic          seg_valid,
  input  logic          seg_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          err_evt,
  output logic [CW-1:0] bit_cnt,
  output logic [CW-1:0] err_cnt,
  output logic          cnt_ovf,
  output logic [AW:0]   cap_fill,
  output logic          cap_done
);
  localparam int HALF = DEPTH / 2;
  localparam int HW   = AW - 1;
  localparam int NW   = $clog2(W + 1);

  logic          run, trig;
  logic [AW-1:0] wptr;
  logic [W-1:0]  lo_mem [HALF];
  logic [W-1:0]  hi_mem [HALF];

  wire errcap  = (mode == 2'b01);
  wire act     = run && in_valid && seg_valid;
  wire cmp_act = act && (mode != 2'b00) && !seg_mask;
  wire [W-1:0] diff = (smp_data ^ exp_data) & ~bit_mask & {W{cmp_act}};
  wire hit     = |diff;
  wire clr     = clear && (!run || mode[1]);

  wire [NW-1:0] n_bits = cmp_act ? NW'($countones(~bit_mask)) : '0;
  wire [NW-1:0] n_err  = NW'($countones(diff));
  wire [CW:0]   bit_sum = {1'b0, bit_cnt} + (CW+1)'(n_bits);
  wire [CW:0]   err_sum = {1'b0, err_cnt} + (CW+1)'(n_err);

  wire store_ok = act && !cap_done && !mode[1] && (!errcap || pre_trig || trig || hit);
  wire [AW:0] lim     = errcap ? (AW+1)'(HALF) : (AW+1)'(DEPTH);
  wire [AW:0] fill_p1 = cap_fill + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 1'b0;
    else if (start) run <= 1'b1;
    else if (stop) run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bit_cnt <= '0;
      err_cnt <= '0;
      cnt_ovf <= 1'b0;
    end else if (cmp_act) begin
      bit_cnt <= bit_sum[CW] ? '1 : bit_sum[CW-1:0];
      err_cnt <= err_sum[CW] ? '1 : err_sum[CW-1:0];
      if (bit_sum[CW] || err_sum[CW]) cnt_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_evt <= 1'b0;
    else err_evt <= hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr     <= '0;
      cap_fill <= '0;
      cap_done <= 1'b0;
      trig     <= 1'b0;
    end else if (store_ok) begin
      wptr <= errcap ? {1'b0, wptr[HW-1:0] + 1'b1} : wptr + 1'b1;
      if (hit) trig <= 1'b1;
      if (errcap && pre_trig) begin
        if (cap_fill != lim) cap_fill <= fill_p1;
        cap_done <= hit;
      end else begin
        cap_fill <= fill_p1;
        cap_done <= (fill_p1 == lim);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store_ok) begin
      if (errcap) begin
        lo_mem[wptr[HW-1:0]] <= smp_data;
        hi_mem[wptr[HW-1:0]] <= exp_data;
      end else if (!wptr[AW-1]) begin
        lo_mem[wptr[HW-1:0]] <= smp_data;
      end else begin
        hi_mem[wptr[HW-1:0]] <= smp_data;
      end
    end
  end

  wire [HW-1:0] base = (errcap && cap_fill == lim) ? wptr[HW-1:0] : '0;
  wire [HW-1:0] ridx = errcap ? rd_addr[HW-1:0] + base : rd_addr[HW-1:0];
  assign rd_data = rd_addr[AW-1] ? hi_mem[ridx] : lo_mem[ridx];
endmodule

module err_cap_ber_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          clear,
  input logic          err_evt,
  input logic [CW-1:0] bit_cnt,
  input logic [CW-1:0] err_cnt,
  input logic          cnt_ovf,
  input logic [AW:0]   cap_fill,
  input logic          cap_done
);
  // R4
  err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= bit_cnt);
  // R12
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear) |-> (bit_cnt >= $past(bit_cnt)) && (err_cnt >= $past(err_cnt)));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_ovf) && !$past(clear)) |-> cnt_ovf);
  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fill <= (AW+1)'(DEPTH));
  // R8
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $stable(mode) && $past(cap_fill) <= (AW+1)'(DEPTH/2))
      |-> cap_fill <= (AW+1)'(DEPTH/2));
  // R2
  cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00 && !$past(clear)) |-> ($stable(bit_cnt) && $stable(err_cnt)));
  // R6
  evt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> $past(mode) != 2'b00);
  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_done) && !$past(clear)) |-> cap_done);
endmodule

bind err_cap_ber err_cap_ber_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .clear(clear), .err_evt(err_evt),
  .bit_cnt(bit_cnt), .err_cnt(err_cnt), .cnt_ovf(cnt_ovf),
  .cap_fill(cap_fill), .cap_done(cap_done));

// File: tb/sim_err_cap_ber.sv
module sim_err_cap_ber;
  localparam int W = 4, DEPTH = 8, CW = 16, AW = 3, HALF = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic pre_trig = 0, start = 0, stop = 0, clear = 0, in_valid = 0;
  logic [W-1:0] smp_data = 0, exp_data = 0, bit_mask = 0;
  logic seg_valid = 0, seg_mask = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [W-1:0] rd_data;
  logic err_evt, cnt_ovf, cap_done;
  logic [CW-1:0] bit_cnt, err_cnt;
  logic [AW:0] cap_fill;

  int checks = 0, fails = 0;
  longint eb, ee;

  always #4 clk = ~clk;

  err_cap_ber #(.W(W), .DEPTH(DEPTH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pre_trig(pre_trig), .start(start),
    .stop(stop), .clear(clear), .in_valid(in_valid), .smp_data(smp_data),
    .exp_data(exp_data), .bit_mask(bit_mask), .seg_valid(seg_valid),
    .seg_mask(seg_mask), .rd_addr(rd_addr), .rd_data(rd_data), .err_evt(err_evt),
    .bit_cnt(bit_cnt), .err_cnt(err_cnt), .cnt_ovf(cnt_ovf), .cap_fill(cap_fill),
    .cap_done(cap_done));

  task automatic chk(string r, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_start(); start = 1; tick(); start = 0; endtask
  task automatic pulse_stop();  stop = 1;  tick(); stop = 0;  endtask
  task automatic pulse_clear(); clear = 1; tick(); clear = 0; endtask

  task automatic word(input logic [W-1:0] s, e, m, input logic sm = 0, input logic sv = 1);
    smp_data = s; exp_data = e; bit_mask = m; seg_mask = sm; seg_valid = sv; in_valid = 1;
    tick();
    in_valid = 0; seg_valid = 0; seg_mask = 0;
  endtask

  task automatic rd(input int a, input longint exp, input string r);
    rd_addr = AW'(a); #1;
    chk(r, rd_data, exp);
  endtask

  function automatic int pc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1; tick();
    // R1
    chk("R1 bit_cnt", bit_cnt, 0); chk("R1 err_cnt", err_cnt, 0);
    chk("R1 ovf", cnt_ovf, 0); chk("R1 err_evt", err_evt, 0);
    chk("R1 fill", cap_fill, 0); chk("R1 done", cap_done, 0);

    // R3 start wins over stop; R4 R6 exhaustive sweep in count mode
    mode = 2'b10; start = 1; stop = 1; tick(); start = 0; stop = 0;
    eb = 0; ee = 0;
    for (int s = 0; s < 16; s++)
      for (int e = 0; e < 16; e++)
        for (int m = 0; m < 16; m++) begin
          word(W'(s), W'(e), W'(m));
          eb += W - pc(W'(m));
          ee += pc(W'((s ^ e) & ~m));
          chk("R4 bit_cnt", bit_cnt, eb);
          chk("R4 err_cnt", err_cnt, ee);
          chk("R6 err_evt", err_evt, ((s ^ e) & ~m) != 0);
        end
    // R5 segment mask
    word(4'hF, 4'h0, 4'h0, 1'b1);
    chk("R5 bit_cnt", bit_cnt, eb); chk("R5 err_cnt", err_cnt, ee); chk("R5 err_evt", err_evt, 0);
    // R3 segment invalid, no input valid
    word(4'hF, 4'h0, 4'h0, 1'b0, 1'b0);
    chk("R3 seg_valid low", bit_cnt, eb);
    tick();
    chk("R3 idle", err_cnt, ee);
    // mode 3 also counts
    mode = 2'b11; word(4'h1, 4'h0, 4'h0); eb += 4; ee += 1;
    chk("R2 mode3 bits", bit_cnt, eb); chk("R2 mode3 errs", err_cnt, ee);
    mode = 2'b10;
    // R12 clear honored while counting
    pulse_clear();
    chk("R12 clear running bits", bit_cnt, 0); chk("R12 clear running errs", err_cnt, 0);
    // R3 stopped
    pulse_stop();
    word(4'hF, 4'h0, 4'h0);
    chk("R3 stopped", bit_cnt, 0);

    // R11 saturation
    pulse_start();
    smp_data = 4'hF; exp_data = 4'h0; bit_mask = 0; seg_valid = 1; in_valid = 1;
    repeat (16383) tick();
    in_valid = 0;
    chk("R11 pre-sat bits", bit_cnt, 65532); chk("R11 pre-sat ovf", cnt_ovf, 0);
    word(4'hF, 4'h0, 4'h0);
    chk("R11 sat bits", bit_cnt, 65535); chk("R11 sat errs", err_cnt, 65535);
    chk("R11 ovf", cnt_ovf, 1);
    word(4'h0, 4'h0, 4'h0);
    chk("R11 held", bit_cnt, 65535); chk("R11 sticky", cnt_ovf, 1);
    pulse_stop(); pulse_clear();
    chk("R12 ovf cleared", cnt_ovf, 0); chk("R12 bits cleared", bit_cnt, 0);

    // R7 R2 capture only
    mode = 2'b00; pulse_start();
    for (int i = 0; i < 10; i++) begin
      word(W'(i), W'(~i), 4'h0);
      chk("R7 fill", cap_fill, (i + 1 < DEPTH) ? i + 1 : DEPTH);
      chk("R7 done", cap_done, (i + 1 >= DEPTH));
      chk("R2 no err_evt", err_evt, 0);
    end
    chk("R2 bits frozen", bit_cnt, 0);
    for (int k = 0; k < DEPTH; k++) rd(k, k, "R7 data");
    // R12 clear ignored while running
    pulse_clear();
    chk("R12 ignored fill", cap_fill, DEPTH); chk("R12 ignored done", cap_done, 1);
    pulse_stop(); pulse_clear();
    chk("R12 rearm fill", cap_fill, 0); chk("R12 rearm done", cap_done, 0);

    // R9 R8 before-error window
    mode = 2'b01; pre_trig = 1; pulse_start();
    for (int j = 1; j <= 9; j++) begin
      word(W'(j), W'((j == 7) ? (j ^ 1) : j), 4'h0);
      if (j == 6) chk("R9 not done", cap_done, 0);
      if (j == 7) chk("R9 done", cap_done, 1);
    end
    chk("R9 fill", cap_fill, HALF);
    chk("R4 errcap errs", err_cnt, 1);
    for (int k = 0; k < HALF; k++) begin
      rd(k, 4 + k, "R9 sample");
      rd(HALF + k, (k == 3) ? 6 : 4 + k, "R8 expected");
    end
    pulse_stop(); pulse_clear();

    // R10 after-error window
    pre_trig = 0; pulse_start();
    word(4'h1, 4'h1, 4'h2);
    word(4'h3, 4'h1, 4'h2);
    chk("R10 masked no start", cap_fill, 0); chk("R6 masked evt", err_evt, 0);
    for (int j = 1; j <= 9; j++) begin
      word(W'(j), W'((j == 3) ? (j ^ 2) : j), 4'h0);
      if (j == 2) chk("R10 idle fill", cap_fill, 0);
      if (j == 3) chk("R10 start fill", cap_fill, 1);
      if (j == 5) chk("R10 not done", cap_done, 0);
    end
    chk("R10 fill", cap_fill, HALF); chk("R10 done", cap_done, 1);
    for (int k = 0; k < HALF; k++) rd(k, 3 + k, "R10 sample");
    rd(HALF, 1, "R8 expected first");
    rd(HALF + 1, 4, "R8 expected second");
    pulse_stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule